// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block manages a direct-mapped data cache that sits between a CPU load/store port and a synchronous main-memory bus. The CPU side moves 64-bit words. Each 32-byte line holds four of them. The memory side is 32 bits wide, so one cache word needs two bus beats and one line needs eight. The tag, valid, dirty and sharing state and the data words are held in internal arrays that stand in for external SRAM.

Stores use a write-back policy. A store only marks its line dirty. Main memory sees the data when the line is evicted, and the whole victim line is written out before its replacement is read in. A refill always walks the line in ascending beat order. The CPU is released on the very beat that completes the word it asked for, and the rest of the line keeps filling behind it. Any new request waits until that fill ends.

Every byte of every stored word carries an even-parity bit. A mismatch on a CPU load sets an error flag, and the data is returned as stored, without correction. A snoop-style query port reports whether an address is cached, dirty or shared. A qualified snoop hit marks its line as shared.

Top module: `dc_cache_top`

## Requirements
- R1: After reset, `cpu_ready_o` and `mem_req_o` are low and every line is invalid. A snoop query reports no hit, and the first access to any address misses.
- R2: A load that hits while no miss is in progress completes in the cycle it is presented, with no bus traffic. `cpu_rdata_o` returns the stored 64-bit word.
- R3: A miss on a clean line performs eight read beats and no write beats. The beat addresses ascend by 4 from the line base. Address bits [11:9] are the tag, [8:5] the index, [4:3] the word and [2] the half. The half at the lower address forms bits [31:0] of the word.
- R4: On a load miss to word w, `cpu_ready_o` rises in the cycle of the accepted read beat 2w+1 (counting from 0), with the full requested word. The fill then continues to beat 7.
- R5: A store hit completes in its first cycle and starts no bus cycle. The line becomes dirty, main memory is unchanged, and later loads return the stored word.
- R6: A miss on a dirty line first writes all eight victim beats in ascending order from the victim's base, and only then starts the eight read beats. Memory then holds the stored data.
- R7: Parity is even, one bit per byte: `mem_rpar_i[k]` and `mem_wpar_o[k]` cover data bits [8k+7:8k]. If the stored parity of a loaded word disagrees with its data, `cpu_perr_o` is high together with `cpu_ready_o` and the data is returned unchanged. Other words report no error.
- R8: Once the CPU has been released early, any further CPU request stalls until the fill has finished (`mem_req_o` low).
- R9: `snoop_hit_o` is high when `snoop_addr_i` matches a valid line. `snoop_dirty_o` and `snoop_shared_o` show that line's state. A cycle with `snoop_valid_i` high on a hit sets the shared bit. A refill of the line clears it.
- R10: A store miss allocates the line and is released at beat 2w+1 with its word merged in. The line is dirty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU request, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Byte address, word aligned |
| cpu_wdata_i | input | 64 | Store data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | 64 | Load data, valid with ready |
| cpu_perr_o | output | 1 | Parity error on the load, valid with ready |
| mem_req_o | output | 1 | Bus beat request |
| mem_we_o | output | 1 | 1 = write beat |
| mem_addr_o | output | ADDR_W | Beat byte address |
| mem_wdata_o | output | 32 | Write beat data |
| mem_wpar_o | output | 4 | Write beat byte parity |
| mem_ack_i | input | 1 | Beat accepted this cycle |
| mem_rdata_i | input | 32 | Read beat data |
| mem_rpar_i | input | 4 | Read beat byte parity |
| snoop_valid_i | input | 1 | Snoop probe that marks a hit line shared |
| snoop_addr_i | input | ADDR_W | Snoop query address |
| snoop_hit_o | output | 1 | Query address is cached |
| snoop_dirty_o | output | 1 | Matching line is dirty |
| snoop_shared_o | output | 1 | Matching line is shared |

## Verification
The bench counts accepted read beats at the moment the CPU is released. A design that waited for the whole line, or released one beat early on the lower half alone, would show the wrong count or a half-stale word. A dirty eviction is checked for beat order and content. A controller that read before writing back, or that wrote main memory on a store hit, would leave memory holding the wrong words. Bad parity is injected on a single read beat to show the flag tracks that word alone. A request placed right after an early release must be held off until the fill finishes; a design that served it early would answer while the bus is still busy. Snoop probes check that the shared bit is set on a hit and cleared on refill.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_RD} dc_state_e;

  // even parity: one bit per byte
  function automatic logic [7:0] byte_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 3,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [TAG_W-1:0] lk_tag_o,
  output logic             lk_valid_o,
  output logic             lk_dirty_o,
  input  logic [IDX_W-1:0] sn_idx_i,
  output logic [TAG_W-1:0] sn_tag_o,
  output logic             sn_valid_o,
  output logic             sn_dirty_o,
  output logic             sn_shared_o,
  input  logic [IDX_W-1:0] w_idx_i,
  input  logic             inv_i,
  input  logic             mark_dirty_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_dirty_i,
  input  logic             sn_mark_i
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  valid_q, dirty_q, shared_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q    <= '{default: '0};
      valid_q  <= '0;
      dirty_q  <= '0;
      shared_q <= '0;
    end else begin
      if (sn_mark_i) shared_q[sn_idx_i] <= 1'b1;
      if (inv_i) begin
        valid_q[w_idx_i]  <= 1'b0;
        dirty_q[w_idx_i]  <= 1'b0;
        shared_q[w_idx_i] <= 1'b0;
      end
      if (mark_dirty_i) dirty_q[w_idx_i] <= 1'b1;
      if (fill_i) begin
        valid_q[w_idx_i]  <= 1'b1;
        tag_q[w_idx_i]    <= fill_tag_i;
        dirty_q[w_idx_i]  <= fill_dirty_i;
        shared_q[w_idx_i] <= 1'b0;
      end
    end
  end

  assign lk_tag_o    = tag_q[lk_idx_i];
  assign lk_valid_o  = valid_q[lk_idx_i];
  assign lk_dirty_o  = dirty_q[lk_idx_i];
  assign sn_tag_o    = tag_q[sn_idx_i];
  assign sn_valid_o  = valid_q[sn_idx_i];
  assign sn_dirty_o  = dirty_q[sn_idx_i];
  assign sn_shared_o = shared_q[sn_idx_i];

  // R6
  dirty_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_dirty_o |-> lk_valid_o);
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int ENT    = SETS * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [WORD_W-1:0] w_word_i,
  input  logic [1:0]        w_mask_i,
  input  logic [63:0]       w_data_i,
  input  logic [7:0]        w_par_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [WORD_W-1:0] ra_word_i,
  output logic [63:0]       ra_data_o,
  output logic [7:0]        ra_par_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  input  logic [WORD_W-1:0] rb_word_i,
  output logic [63:0]       rb_data_o,
  output logic [7:0]        rb_par_o
);
  // one array per 32-bit half so a bus beat writes only its own half
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [31:0] d_q [ENT];
    logic [3:0]  p_q [ENT];

    always_ff @(posedge clk_i) begin
      if (we_i && w_mask_i[h]) begin
        d_q[{w_idx_i, w_word_i}] <= w_data_i[32*h +: 32];
        p_q[{w_idx_i, w_word_i}] <= w_par_i[4*h +: 4];
      end
    end

    assign ra_data_o[32*h +: 32] = d_q[{ra_idx_i, ra_word_i}];
    assign ra_par_o[4*h +: 4]    = p_q[{ra_idx_i, ra_word_i}];
    assign rb_data_o[32*h +: 32] = d_q[{rb_idx_i, rb_word_i}];
    assign rb_par_o[4*h +: 4]    = p_q[{rb_idx_i, rb_word_i}];
  end
endmodule

// File: rtl/dc_cache_top.sv
module dc_cache_top #(
  parameter int ADDR_W     = 12,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [63:0]       cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [63:0]       cpu_rdata_o,
  output logic              cpu_perr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_wpar_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic [3:0]        mem_rpar_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              snoop_hit_o,
  output logic              snoop_dirty_o,
  output logic              snoop_shared_o
);
  import dc_pkg::*;

  localparam int IDX_W  = $clog2(SETS);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int BEAT_W = WORD_W + 1;
  localparam int OFF_W  = WORD_W + 3;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(2*LINE_WORDS - 1);

  dc_state_e         st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q, vtag_q;
  logic [WORD_W-1:0] word_q;
  logic              we_q, rel_q;
  logic [63:0]       wdata_q;

  logic [IDX_W-1:0]  cpu_idx, sn_idx;
  logic [TAG_W-1:0]  cpu_tag, sn_tag_in;
  logic [WORD_W-1:0] cpu_word;
  logic [TAG_W-1:0]  lk_tag, sn_tag;
  logic              lk_valid, lk_dirty, sn_valid, sn_dirty, sn_shared;
  logic              idle, hit, miss, crit, last_ack;

  assign cpu_idx   = cpu_addr_i[OFF_W +: IDX_W];
  assign cpu_tag   = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_word  = cpu_addr_i[3 +: WORD_W];
  assign sn_idx    = snoop_addr_i[OFF_W +: IDX_W];
  assign sn_tag_in = snoop_addr_i[ADDR_W-1 -: TAG_W];

  assign idle     = (st_q == ST_IDLE);
  assign hit      = lk_valid && (lk_tag == cpu_tag);
  assign miss     = idle && cpu_req_i && !hit;
  assign crit     = (st_q == ST_RD) && mem_ack_i && (beat_q == {word_q, 1'b1});
  assign last_ack = (st_q == ST_RD) && mem_ack_i && (beat_q == LAST_BEAT);

  // data array ports
  logic [63:0] ra_data, rb_data, w_data;
  logic [7:0]  ra_par, rb_par, w_par;
  logic        d_we;
  logic [WORD_W-1:0] w_word;
  logic [1:0]  w_mask;

  always_comb begin
    d_we   = 1'b0;
    w_word = cpu_word;
    w_mask = 2'b11;
    w_data = cpu_wdata_i;
    w_par  = byte_par(cpu_wdata_i);
    if (idle) begin
      d_we = cpu_req_i && hit && cpu_we_i;
    end else if (st_q == ST_RD && mem_ack_i) begin
      d_we = 1'b1;
      if (crit && we_q) begin
        w_word = word_q;
        w_data = wdata_q;
        w_par  = byte_par(wdata_q);
      end else begin
        w_word = beat_q[BEAT_W-1:1];
        w_mask = beat_q[0] ? 2'b10 : 2'b01;
        w_data = {mem_rdata_i, mem_rdata_i};
        w_par  = {mem_rpar_i, mem_rpar_i};
      end
    end
  end

  dc_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk_i    (clk_i),
    .we_i     (d_we),
    .w_idx_i  (idle ? cpu_idx : idx_q),
    .w_word_i (w_word),
    .w_mask_i (w_mask),
    .w_data_i (w_data),
    .w_par_i  (w_par),
    .ra_idx_i (idle ? cpu_idx : idx_q),
    .ra_word_i(idle ? cpu_word : word_q),
    .ra_data_o(ra_data),
    .ra_par_o (ra_par),
    .rb_idx_i (idx_q),
    .rb_word_i(beat_q[BEAT_W-1:1]),
    .rb_data_o(rb_data),
    .rb_par_o (rb_par)
  );

  dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (cpu_idx),
    .lk_tag_o    (lk_tag),
    .lk_valid_o  (lk_valid),
    .lk_dirty_o  (lk_dirty),
    .sn_idx_i    (sn_idx),
    .sn_tag_o    (sn_tag),
    .sn_valid_o  (sn_valid),
    .sn_dirty_o  (sn_dirty),
    .sn_shared_o (sn_shared),
    .w_idx_i     (idle ? cpu_idx : idx_q),
    .inv_i       (miss),
    .mark_dirty_i(idle && cpu_req_i && hit && cpu_we_i),
    .fill_i      (last_ack),
    .fill_tag_i  (tag_q),
    .fill_dirty_i(we_q),
    .sn_mark_i   (snoop_valid_i && snoop_hit_o)
  );

  // CPU response: hit in idle, or early release on the critical beat
  logic [63:0] chk_data;
  logic [7:0]  chk_par;
  assign chk_data    = crit ? {mem_rdata_i, ra_data[31:0]} : ra_data;
  assign chk_par     = crit ? {mem_rpar_i, ra_par[3:0]} : ra_par;
  assign cpu_ready_o = (idle && cpu_req_i && hit) || crit;
  assign cpu_rdata_o = chk_data;
  assign cpu_perr_o  = cpu_ready_o && !(idle ? cpu_we_i : we_q) &&
                       (byte_par(chk_data) != chk_par);

  // memory bus
  assign mem_req_o   = !idle;
  assign mem_we_o    = (st_q == ST_WB);
  assign mem_addr_o  = {(st_q == ST_WB) ? vtag_q : tag_q, idx_q, beat_q, 2'b00};
  assign mem_wdata_o = beat_q[0] ? rb_data[63:32] : rb_data[31:0];
  assign mem_wpar_o  = beat_q[0] ? rb_par[7:4] : rb_par[3:0];

  // snoop query
  assign snoop_hit_o    = sn_valid && (sn_tag == sn_tag_in);
  assign snoop_dirty_o  = snoop_hit_o && sn_dirty;
  assign snoop_shared_o = snoop_hit_o && sn_shared;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      idx_q   <= '0;
      tag_q   <= '0;
      vtag_q  <= '0;
      word_q  <= '0;
      we_q    <= 1'b0;
      rel_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (miss) begin
          idx_q   <= cpu_idx;
          tag_q   <= cpu_tag;
          vtag_q  <= lk_tag;
          word_q  <= cpu_word;
          we_q    <= cpu_we_i;
          wdata_q <= cpu_wdata_i;
          beat_q  <= '0;
          rel_q   <= 1'b0;
          st_q    <= (lk_valid && lk_dirty) ? ST_WB : ST_RD;
        end
        ST_WB: if (mem_ack_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_q <= ST_RD;
        end
        ST_RD: if (mem_ack_i) begin
          beat_q <= beat_q + 1'b1;
          if (crit) rel_q <= 1'b1;
          if (beat_q == LAST_BEAT) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  beat_ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && beat_q != LAST_BEAT) |=>
      (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

  // R6
  wb_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i && beat_q == LAST_BEAT) |=>
      (mem_req_o && !mem_we_o));

  // R4
  release_on_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && mem_req_o) |-> (mem_ack_i && !mem_we_o));

  // R8
  single_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && mem_req_o) |-> !rel_q);

  // R5
  store_hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && cpu_ready_o && !mem_req_o) |=> !mem_req_o);
endmodule

// File: tb/dc_cache_top_test.sv
module dc_cache_top_test;
  localparam int ADDR_W = 12;
  localparam int MWORDS = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [63:0]       cpu_wdata = '0;
  logic              cpu_ready_o, cpu_perr_o;
  logic [63:0]       cpu_rdata_o;
  logic              mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0]       mem_wdata_o;
  logic [3:0]        mem_wpar_o;
  logic              mem_ack = 1'b0;
  logic [31:0]       mem_rdata = '0;
  logic [3:0]        mem_rpar = '0;
  logic              snoop_valid = 1'b0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic              snoop_hit_o, snoop_dirty_o, snoop_shared_o;

  dc_cache_top #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready_o),
    .cpu_rdata_o(cpu_rdata_o), .cpu_perr_o(cpu_perr_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_wpar_o(mem_wpar_o), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .mem_rpar_i(mem_rpar),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .snoop_hit_o(snoop_hit_o), .snoop_dirty_o(snoop_dirty_o),
    .snoop_shared_o(snoop_shared_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem     [MWORDS];
  logic [31:0] ref_mem [MWORDS];
  logic [31:0] init_mem[MWORDS];
  logic [ADDR_W-1:0] rd_log [8];
  logic [ADDR_W-1:0] wr_log [8];
  logic [ADDR_W-1:0] bad_addr = '1;
  int rd_beats = 0, wr_beats = 0, seq = 0, first_rd_seq = 0, last_wr_seq = 0, tick = 0;
  logic [64:0] exp_q [$];

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] p4(input logic [31:0] d);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = ^d[8*k +: 8];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int t, input int i, input int w);
    return ADDR_W'((t << 9) | (i << 5) | (w << 3));
  endfunction

  function automatic logic [63:0] ref_word(input logic [ADDR_W-1:0] a);
    return {ref_mem[a[ADDR_W-1:2] + 1], ref_mem[a[ADDR_W-1:2]]};
  endfunction

  // memory model: answers beats with a fixed wait pattern
  always @(negedge clk) begin
    tick++;
    mem_ack = 1'b0;
    if (mem_req_o && (tick % 4 != 1)) begin
      mem_ack = 1'b1;
      seq++;
      if (mem_we_o) begin
        mem[mem_addr_o[ADDR_W-1:2]] = mem_wdata_o;
        wr_log[wr_beats % 8] = mem_addr_o;
        wr_beats++;
        last_wr_seq = seq;
      end else begin
        mem_rdata = mem[mem_addr_o[ADDR_W-1:2]];
        mem_rpar  = p4(mem_rdata) ^ ((mem_addr_o == bad_addr) ? 4'b0001 : 4'b0000);
        if (rd_beats % 8 == 0) first_rd_seq = seq;
        rd_log[rd_beats % 8] = mem_addr_o;
        rd_beats++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (cpu_req && cpu_ready_o && !cpu_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected load result", cpu_rdata_o, '0);
      end else begin
        logic [64:0] e;
        e = exp_q.pop_front();
        check(cpu_rdata_o == e[63:0], "R2/R4 load data", cpu_rdata_o, e[63:0]);
        check(cpu_perr_o == e[64], "R7 parity flag", 64'(cpu_perr_o), 64'(e[64]));
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] a, input logic [63:0] wd,
                        input bit exp_perr, output int waits, output int beats, output bit mreq);
    int start_rd;
    start_rd = rd_beats;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (!we) exp_q.push_back({exp_perr, ref_word(a)});
    waits = 0;
    forever begin
      #1;
      if (cpu_ready_o) break;
      @(negedge clk);
      waits++;
    end
    beats = rd_beats - start_rd;
    mreq = mem_req_o;
    @(posedge clk);
    #1 cpu_req = 1'b0;
    if (we) begin
      ref_mem[a[ADDR_W-1:2]]     = wd[31:0];
      ref_mem[a[ADDR_W-1:2] + 1] = wd[63:32];
    end
  endtask

  task automatic settle();
    @(negedge clk);
    while (mem_req_o) @(negedge clk);
  endtask

  task automatic snoop_chk(input logic [ADDR_W-1:0] a, input bit h, input bit d, input bit s, input string rq);
    @(negedge clk);
    snoop_addr = a;
    #1;
    check({snoop_hit_o, snoop_dirty_o, snoop_shared_o} == {h, d, s}, rq,
          64'({snoop_hit_o, snoop_dirty_o, snoop_shared_o}), 64'({h, d, s}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w, b, wb0, rd0;
    bit mq, ok;
    logic [63:0] d1, d2;
    d1 = 64'hDEAD_BEEF_0123_4567;
    d2 = 64'h55AA_3C3C_F00D_CAFE;
    for (int i = 0; i < MWORDS; i++) begin
      init_mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
      mem[i] = init_mem[i];
      ref_mem[i] = init_mem[i];
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(cpu_ready_o == 1'b0, "R1 ready in reset", 64'(cpu_ready_o), 0);
    check(mem_req_o == 1'b0, "R1 bus idle in reset", 64'(mem_req_o), 0);
    @(negedge clk) rst_n = 1'b1;
    snoop_chk(mk(0, 0, 0), 0, 0, 0, "R1 no line valid after reset");

    // R3/R4: clean miss, word 2 -> release at beat 5 (6 beats)
    cpu_op(0, mk(0, 1, 2), '0, 0, w, b, mq);
    check(b == 6, "R4 release beat count word2", 64'(b), 6);
    settle();
    ok = 1'b1;
    for (int k = 0; k < 8; k++) if (rd_log[k] != mk(0, 1, 0) + ADDR_W'(4*k)) ok = 1'b0;
    check(ok, "R3 ascending read beats", 64'(rd_log[1]), 64'(mk(0, 1, 0) + 4));
    check(wr_beats == 0, "R3 no write on clean miss", 64'(wr_beats), 0);

    // R2: hit completes at once
    rd0 = rd_beats;
    cpu_op(0, mk(0, 1, 0), '0, 0, w, b, mq);
    check(w == 0, "R2 hit wait cycles", 64'(w), 0);
    check(rd_beats == rd0, "R2 hit has no bus beats", 64'(rd_beats), 64'(rd0));

    // R4: last word released on the final beat
    cpu_op(0, mk(1, 2, 3), '0, 0, w, b, mq);
    check(b == 8, "R4 release beat count word3", 64'(b), 8);
    settle();

    // R5: store hit
    wb0 = wr_beats;
    cpu_op(1, mk(0, 1, 1), d1, 0, w, b, mq);
    check(w == 0, "R5 store hit wait cycles", 64'(w), 0);
    settle();
    check(wr_beats == wb0, "R5 no write beats on store hit", 64'(wr_beats), 64'(wb0));
    check(mem[mk(0, 1, 1) >> 2] == init_mem[mk(0, 1, 1) >> 2], "R5 memory untouched",
          64'(mem[mk(0, 1, 1) >> 2]), 64'(init_mem[mk(0, 1, 1) >> 2]));
    snoop_chk(mk(0, 1, 0), 1, 1, 0, "R9 snoop sees dirty line");
    cpu_op(0, mk(0, 1, 1), '0, 0, w, b, mq);  // R5 stored data returned

    // R8: early release then immediate request
    cpu_op(0, mk(0, 3, 0), '0, 0, w, b, mq);
    check(b == 2, "R4 release beat count word0", 64'(b), 2);
    cpu_op(0, mk(0, 1, 1), '0, 0, w, b, mq);
    check(mq == 1'b0 && (rd_beats % 8) == 0, "R8 request held until fill done",
          64'(rd_beats % 8), 0);
    check(w > 0, "R8 request stalled", 64'(w), 1);

    // R6: dirty eviction
    wb0 = wr_beats;
    cpu_op(0, mk(2, 1, 0), '0, 0, w, b, mq);
    check(b == 2, "R6 release after write-back", 64'(b), 2);
    settle();
    check(wr_beats - wb0 == 8, "R6 eight write beats", 64'(wr_beats - wb0), 8);
    ok = 1'b1;
    for (int k = 0; k < 8; k++) if (wr_log[k] != mk(0, 1, 0) + ADDR_W'(4*k)) ok = 1'b0;
    check(ok, "R6 victim beats ascending", 64'(wr_log[0]), 64'(mk(0, 1, 0)));
    check({mem[(mk(0, 1, 1) >> 2) + 1], mem[mk(0, 1, 1) >> 2]} == d1, "R6 victim data in memory",
          {mem[(mk(0, 1, 1) >> 2) + 1], mem[mk(0, 1, 1) >> 2]}, d1);
    check(first_rd_seq > last_wr_seq, "R6 reads follow write-back",
          64'(first_rd_seq), 64'(last_wr_seq + 1));

    // R10: store miss
    cpu_op(1, mk(0, 4, 2), d2, 0, w, b, mq);
    check(b == 6, "R10 store miss release beat", 64'(b), 6);
    cpu_op(0, mk(0, 4, 2), '0, 0, w, b, mq);
    snoop_chk(mk(0, 4, 0), 1, 1, 0, "R10 store miss line dirty");

    // R7: bad parity on one read beat
    bad_addr = mk(0, 5, 1);
    cpu_op(0, mk(0, 5, 1), '0, 1, w, b, mq);
    cpu_op(0, mk(0, 5, 0), '0, 0, w, b, mq);
    cpu_op(0, mk(0, 5, 1), '0, 1, w, b, mq);
    bad_addr = '1;

    // R9: snoop state
    snoop_chk(mk(1, 2, 0), 1, 0, 0, "R9 clean line");
    @(negedge clk) begin snoop_addr = mk(1, 2, 0); snoop_valid = 1'b1; end
    @(posedge clk);
    #1 snoop_valid = 1'b0;
    snoop_chk(mk(1, 2, 0), 1, 0, 1, "R9 shared after probe");
    snoop_chk(mk(3, 2, 0), 0, 0, 0, "R9 other tag misses");
    wb0 = wr_beats;
    cpu_op(0, mk(3, 2, 0), '0, 0, w, b, mq);
    settle();
    check(wr_beats == wb0, "R9 clean victim not written", 64'(wr_beats), 64'(wb0));
    snoop_chk(mk(3, 2, 0), 1, 0, 0, "R9 shared cleared by refill");
    snoop_chk(mk(1, 2, 0), 0, 0, 0, "R9 old tag gone");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all loads answered", 64'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule